// File: doc/BRIEF.md
# Grouped Prescaler and Tick Divider for a Multi-Channel Timer

This block turns one free-running base clock into a set of per-channel count-enable strobes for a five-channel PWM timer. Two 8-bit prescalers divide the base clock by their programmed value plus one. The first prescaler feeds the two lowest channels and the second feeds the remaining three. Behind its prescaler, every channel has its own power-of-two divider. A 4-bit code picks the ratio, and a build-time offset of 0 or 1 is added to the code's exponent. Codes flagged in a build-time mask instead pass through a pulse taken from an external tick pin. External pin 0 serves the lower group and pin 1 serves the upper group.

Software programs the block through a write-only register port. The word at byte offset 0x00 holds both prescaler values: group 0 in bits [7:0] and group 1 in bits [15:8]. The word at offset 0x04 holds one 4-bit select code per channel, with channel c in bits [4c+3:4c]. Each output is a strobe in the base clock domain. A downstream timer counter advances once for every cycle in which its strobe is high.

Top module: `pwm_tick_source`

## Requirements
- R1: After reset both prescaler values and all select codes are zero. No strobe is high while reset is asserted. With the default build (exponent offset 1), each channel then strobes on every second clock.
- R2: A prescaler holding value P produces one internal tick every P+1 base clocks. Group 0 takes its value from bits [7:0] of the word written at offset 0x00, and group 1 takes its value from bits [15:8].
- R3: Channels 0 and 1 count ticks of the group 0 prescaler. Channels 2, 3 and 4 count ticks of the group 1 prescaler.
- R4: A divided channel with code k strobes once per 2^e prescaler ticks, where e = min(k+1, 4) in the default build. Code 0 gives 2, code 1 gives 4, code 2 gives 8, code 3 gives 16, and codes 5 to 15 also give 16. Channel c takes its code from bits [4c+3:4c] of the word at offset 0x04. The strobe coincides with the prescaler tick that completes the count.
- R5: A channel whose code is set in the external mask strobes on the external tick instead of its divider. The default mask holds only code 4. Pin 0 serves channels 0 and 1, and pin 1 serves channels 2 to 4.
- R6: The external pins are resynchronized through two flops. A rising edge first seen at clock edge n gives exactly one strobe, in the cycle after edge n+1. A level held high gives no further strobes, and an edge on one pin reaches no channel of the other group.
- R7: A write to offset 0x00 restarts both prescalers and all dividers. A prescaler with new value P ticks first in the (P+1)-th cycle after the write, and a channel dividing by N strobes first on the N-th such tick.
- R8: A write to offset 0x04 clears all divider counts and leaves the prescaler phase unchanged.
- R9: Writes to any other offset change no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| ext_tick_in | input | 2 | Asynchronous external tick pins, one per group |
| ch_tick | output | 5 | Per-channel count-enable strobes |

## Verification
A prescaler or divider counter in the wrong state shifts the phase or spacing of the strobes. A channel whose ratio is 16 ticks through a slow prescaler can take up to 16×256 clocks to show it. The bench therefore compares every strobe against a behavioural model on every clock, starting right after reset. A fault in the resynchronizer shows within three clocks of an external edge, as a strobe that is missing, doubled or early. A decode fault in the write logic shows on the first strobe after the write.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;

   localparam int unsigned NUM_GROUPS     = 2;
   localparam int unsigned CFG_DATA_W     = 32;
   localparam int unsigned PRESCALE_OFS   = 32'h00;
   localparam int unsigned SELECT_OFS     = 32'h04;

   typedef enum logic {
      SRC_DIVIDED  = 1'b0,
      SRC_EXTERNAL = 1'b1
   } tick_src_e;

   // exponent of the divide ratio: code plus build offset, saturated
   function automatic int unsigned clamp_exp(input int unsigned code,
                                             input int unsigned base,
                                             input int unsigned max_e);
      int unsigned e;
      e = code + base;
      if (e > max_e) e = max_e;
      return e;
   endfunction

   // which prescaler group a channel belongs to
   function automatic int unsigned group_of(input int unsigned ch,
                                            input int unsigned split);
      return (ch < split) ? 0 : 1;
   endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] div_val,
   output logic         tick
);

   logic [W-1:0] cnt;

   assign tick = (cnt == div_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

   // R2: the count never runs past the programmed terminal value
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= div_val);

   // R7: the cycle right after a restart holds no tick unless value is zero
   assert_restart_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(restart) && (div_val != '0)) |-> !tick);

endmodule

// File: rtl/ext_tick_sync.sv
module ext_tick_sync (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic pulse
);

   logic meta_q;
   logic sync_q;
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= 1'b0;
         sync_q <= 1'b0;
         prev_q <= 1'b0;
      end else begin
         meta_q <= async_in;
         sync_q <= meta_q;
         prev_q <= sync_q;
      end
   end

   assign pulse = sync_q & ~prev_q;

   // R6: an external edge yields a single-cycle strobe
   assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

endmodule

// File: rtl/tick_divider.sv
module tick_divider
   import pwm_tick_pkg::*;
#(
   parameter int unsigned            SEL_W    = 4,
   parameter int unsigned            MAX_EXP  = 4,
   parameter int unsigned            DIV_BASE = 1,
   parameter logic [2**SEL_W-1:0]    EXT_MASK = 16'h0010
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic [SEL_W-1:0] sel,
   input  logic             pre_tick,
   input  logic             ext_pulse,
   output logic             tick
);

   localparam int unsigned CW = MAX_EXP;

   logic [CW-1:0] dcnt;
   logic [CW-1:0] term;
   logic          hit;
   tick_src_e     src;

   assign term = CW'((32'd1 << clamp_exp(32'(sel), DIV_BASE, MAX_EXP)) - 32'd1);
   assign hit  = (dcnt == term);
   assign src  = EXT_MASK[sel] ? SRC_EXTERNAL : SRC_DIVIDED;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dcnt <= '0;
      else if (clear)    dcnt <= '0;
      else if (pre_tick) dcnt <= hit ? '0 : dcnt + 1'b1;
   end

   always_comb begin
      unique case (src)
         SRC_EXTERNAL: tick = ext_pulse;
         default:      tick = pre_tick & hit;
      endcase
   end

   // R4: the divider count stays below the selected ratio
   assert_dcnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dcnt <= term);

   // R8: just after a clear a divided channel with ratio above one is quiet
   assert_clear_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clear) && (src == SRC_DIVIDED) && (term != '0)) |-> !tick);

endmodule

// File: rtl/pwm_tick_source.sv
module pwm_tick_source
   import pwm_tick_pkg::*;
#(
   parameter int unsigned         NUM_CH   = 5,
   parameter int unsigned         PRE_W    = 8,
   parameter int unsigned         SEL_W    = 4,
   parameter int unsigned         MAX_EXP  = 4,
   parameter int unsigned         DIV_BASE = 1,
   parameter int unsigned         SPLIT_CH = 2,
   parameter int unsigned         ADDR_W   = 8,
   parameter logic [2**SEL_W-1:0] EXT_MASK = 16'h0010
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [CFG_DATA_W-1:0] wr_data,
   input  logic [NUM_GROUPS-1:0] ext_tick_in,
   output logic [NUM_CH-1:0]     ch_tick
);

   localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(PRESCALE_OFS);
   localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(SELECT_OFS);

   initial begin
      assert_param_pre_fit: assert (NUM_GROUPS * PRE_W <= CFG_DATA_W)
         else $fatal(1, "prescaler fields exceed the data word");
      assert_param_sel_fit: assert (NUM_CH * SEL_W <= CFG_DATA_W)
         else $fatal(1, "select fields exceed the data word");
      assert_param_base: assert (DIV_BASE <= 1)
         else $fatal(1, "exponent offset must be 0 or 1");
      assert_param_exp: assert (MAX_EXP >= 1 && MAX_EXP <= 16)
         else $fatal(1, "maximum exponent out of range");
      assert_param_split: assert (SPLIT_CH >= 1 && SPLIT_CH < NUM_CH)
         else $fatal(1, "group split must leave both groups populated");
      assert_param_addr: assert (ADDR_W >= 3)
         else $fatal(1, "address too narrow for both offsets");
   end

   logic [NUM_GROUPS-1:0][PRE_W-1:0] pre_q;
   logic [NUM_CH-1:0][SEL_W-1:0]     sel_q;
   logic                             pre_wr;
   logic                             sel_wr;
   logic                             div_clear;
   logic [NUM_GROUPS-1:0]            grp_tick;
   logic [NUM_GROUPS-1:0]            grp_ext;
   logic                             unused_wdata;

   assign pre_wr       = wr_en && (wr_addr == PRE_ADDR);
   assign sel_wr       = wr_en && (wr_addr == SEL_ADDR);
   assign div_clear    = pre_wr | sel_wr;
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         sel_q <= '0;
      end else begin
         if (pre_wr) begin
            for (int g = 0; g < NUM_GROUPS; g++)
               pre_q[g] <= wr_data[g*PRE_W +: PRE_W];
         end
         if (sel_wr) begin
            for (int c = 0; c < NUM_CH; c++)
               sel_q[c] <= wr_data[c*SEL_W +: SEL_W];
         end
      end
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
      tick_prescaler #(.W(PRE_W)) u_pre (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (pre_wr),
         .div_val (pre_q[g]),
         .tick    (grp_tick[g])
      );

      ext_tick_sync u_ext (
         .clk      (clk),
         .rst_n    (rst_n),
         .async_in (ext_tick_in[g]),
         .pulse    (grp_ext[g])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      localparam int unsigned GRP = group_of(c, SPLIT_CH);

      tick_divider #(
         .SEL_W    (SEL_W),
         .MAX_EXP  (MAX_EXP),
         .DIV_BASE (DIV_BASE),
         .EXT_MASK (EXT_MASK)
      ) u_div (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (div_clear),
         .sel       (sel_q[c]),
         .pre_tick  (grp_tick[GRP]),
         .ext_pulse (grp_ext[GRP]),
         .tick      (ch_tick[c])
      );
   end

endmodule

// File: tb/pwm_tick_source_tb.sv
module pwm_tick_source_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  ext_tick_in = '0;
   logic [4:0]  ch_tick;

   int total = 0;
   int fails = 0;
   bit cmp_on = 1'b0;
   string phase = "R1";

   // behavioural reference state
   int m_pre[2]   = '{0, 0};
   int m_sel[NCH] = '{0, 0, 0, 0, 0};
   int m_pcnt[2]  = '{0, 0};
   int m_dcnt[NCH] = '{0, 0, 0, 0, 0};
   bit m_s1[2] = '{0, 0};
   bit m_s2[2] = '{0, 0};
   bit m_s3[2] = '{0, 0};
   int win[NCH];

   pwm_tick_source u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .ext_tick_in (ext_tick_in),
      .ch_tick     (ch_tick)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int ratio_of(input int code);
      int e;
      e = code + 1;
      if (e > 4) e = 4;
      return 1 << e;
   endfunction

   function automatic int grp(input int c);
      return (c < 2) ? 0 : 1;
   endfunction

   function automatic logic [4:0] model_out();
      logic [4:0] o;
      for (int c = 0; c < NCH; c++) begin
         if (m_sel[c] == 4)
            o[c] = m_s2[grp(c)] && !m_s3[grp(c)];
         else
            o[c] = (m_pcnt[grp(c)] == m_pre[grp(c)]) &&
                   (m_dcnt[c] == ratio_of(m_sel[c]) - 1);
      end
      return o;
   endfunction

   always @(posedge clk) begin
      bit pt[2];
      if (!rst_n) begin
         for (int g = 0; g < 2; g++) begin
            m_pre[g] = 0; m_pcnt[g] = 0; m_s1[g] = 0; m_s2[g] = 0; m_s3[g] = 0;
         end
         for (int c = 0; c < NCH; c++) begin
            m_sel[c] = 0; m_dcnt[c] = 0;
         end
      end else begin
         for (int g = 0; g < 2; g++) pt[g] = (m_pcnt[g] == m_pre[g]);
         for (int c = 0; c < NCH; c++)
            if (pt[grp(c)])
               m_dcnt[c] = (m_dcnt[c] == ratio_of(m_sel[c]) - 1) ? 0 : m_dcnt[c] + 1;
         for (int g = 0; g < 2; g++) m_pcnt[g] = pt[g] ? 0 : m_pcnt[g] + 1;
         if (wr_en && wr_addr == 8'h00) begin
            m_pre[0] = int'(wr_data[7:0]);
            m_pre[1] = int'(wr_data[15:8]);
            for (int g = 0; g < 2; g++) m_pcnt[g] = 0;
            for (int c = 0; c < NCH; c++) m_dcnt[c] = 0;
         end else if (wr_en && wr_addr == 8'h04) begin
            for (int c = 0; c < NCH; c++) begin
               m_sel[c]  = int'(wr_data[c*4 +: 4]);
               m_dcnt[c] = 0;
            end
         end
         for (int g = 0; g < 2; g++) begin
            m_s3[g] = m_s2[g];
            m_s2[g] = m_s1[g];
            m_s1[g] = ext_tick_in[g];
         end
      end
   end

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on) begin
         total++;
         if (ch_tick !== model_out()) begin
            fails++;
            $display("FAIL %s model compare at %0t: actual %b expected %b",
                     phase, $time, ch_tick, model_out());
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = '0; wr_data = '0;
   endtask

   task automatic count_window(input int n);
      for (int c = 0; c < NCH; c++) win[c] = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
         for (int c = 0; c < NCH; c++) if (ch_tick[c]) win[c]++;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; fails++;
      $display("FAIL watchdog expired, actual hung expected done");
      finish_run();
   end

   initial begin
      int first;
      cmp_on = 1'b1;
      // R1: quiet during reset, then every second clock
      phase = "R1";
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); #1;
         check("R1 reset quiet", int'(ch_tick), 0);
      end
      @(negedge clk); rst_n = 1'b1;
      count_window(80);
      for (int c = 0; c < NCH; c++) check("R1 default ratio", win[c], 40);

      // R2: prescaler values and field positions
      phase = "R2";
      reg_write(8'h04, 32'h0);
      reg_write(8'h00, 32'h0000_0003);
      count_window(80);
      check("R2 group0 P=3", win[0], 10);
      check("R2 group1 P=0", win[2], 40);

      // R3: group membership
      phase = "R3";
      reg_write(8'h04, 32'h0001_1111);
      reg_write(8'h00, 32'h0000_0401);
      count_window(80);
      check("R3 ch0 group0", win[0], 10);
      check("R3 ch1 group0", win[1], 10);
      check("R3 ch2 group1", win[2], 4);
      check("R3 ch4 group1", win[4], 4);

      // R4: divider codes and saturation
      phase = "R4";
      reg_write(8'h04, 32'h000F_9230);
      reg_write(8'h00, 32'h0000_0000);
      count_window(80);
      check("R4 code0", win[0], 40);
      check("R4 code3", win[1], 5);
      check("R4 code2", win[2], 10);
      check("R4 code9 clamp", win[3], 5);
      check("R4 code15 clamp", win[4], 5);

      // R9: other offsets ignored
      phase = "R9";
      reg_write(8'h08, 32'hFFFF_FFFF);
      reg_write(8'h0C, 32'h0000_0000);
      count_window(80);
      check("R9 ch0 unchanged", win[0], 40);
      check("R9 ch1 unchanged", win[1], 5);
      check("R9 ch2 unchanged", win[2], 10);

      // R5 / R6: external routing and synchronizer latency
      phase = "R5";
      reg_write(8'h04, 32'h0000_4004);
      count_window(4);
      @(negedge clk); #1;
      ext_tick_in[0] = 1'b1;
      @(negedge clk); #1;
      check("R6 no strobe one edge after", int'(ch_tick[0]), 0);
      @(negedge clk); #1;
      check("R6 strobe two edges after", int'(ch_tick[0]), 1);
      check("R5 other group pin isolated", int'(ch_tick[3]), 0);
      count_window(6);
      check("R6 held level no repeat", win[0], 0);
      ext_tick_in[0] = 1'b0;
      count_window(4);
      ext_tick_in[1] = 1'b1;
      count_window(6);
      check("R5 pin1 to ch3", win[3], 1);
      check("R5 pin1 not ch0", win[0], 0);
      ext_tick_in[1] = 1'b0;
      count_window(4);

      // R7: restart on prescaler write
      phase = "R7";
      reg_write(8'h04, 32'h0);
      reg_write(8'h00, 32'h0000_0500);
      first = -1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk); #1;
         if (ch_tick[2] && first < 0) first = i;
      end
      check("R7 first strobe after restart", first, 10);

      // R8: select write keeps prescaler phase
      phase = "R8";
      reg_write(8'h00, 32'h0000_0203);
      count_window(5);
      reg_write(8'h04, 32'h0000_0000);
      count_window(3);
      reg_write(8'h04, 32'h0000_0101);
      count_window(120);
      check("R8 ch0 ratio4 P=3", win[0], 7);
      check("R8 ch2 ratio4 P=2", win[2], 10);

      cmp_on = 1'b0;
      finish_run();
   end

endmodule